// File: doc/BRIEF.md
# Shared Memory Clock Gating Controller

This block decides whether the shared SDRAM clock runs, and which of three requesters may use the memory. The three requesters are a processor, a DMA engine and a display controller. Its inputs are a flag that selects normal or halt operation and three enable bits: a processor enable, a halt-time DMA enable and a display enable. Its outputs are one access grant for each requester and a registered enable for the memory clock.

When no requester is allowed access, the block does not stop the clock at once. It first raises a self-refresh entry request and waits for the memory side to acknowledge it, so that the memory keeps its contents. Only after that does the clock enable fall. When a requester becomes eligible again, the block turns the clock back on and raises a self-refresh exit request. It releases grants only after the acknowledge has dropped.

All inputs, including the acknowledge, pass through `SYNC_STAGES` register stages. Every output is registered. With the default of one stage, a change on an input appears at the outputs on the second rising edge after it.

Top module: `mem_clk_gate`

## Requirements
- R1: In normal mode (halt_mode = 0), cpu_grant and dma_grant both equal cpu_en once the block is running, and cpu_halt_en has no effect.
- R2: In both modes, disp_grant equals disp_en once the block is running.
- R3: In halt mode (halt_mode = 1), cpu_grant is always 0 and dma_grant equals cpu_halt_en. Toggling cpu_en changes no output.
- R4: While any grant is 1, mem_clk_en is 1. When all three grants would be 0, mem_clk_en settles at 0.
- R5: When every grant becomes ineligible, sr_enter_req rises and mem_clk_en stays 1 for as long as sr_ack stays 0. mem_clk_en falls on the second rising edge after sr_ack rises, and sr_enter_req falls on that same edge.
- R6: No grant is 1 while sr_enter_req or sr_exit_req is 1, or while mem_clk_en is 0.
- R7: From the stopped state, an eligible requester causes mem_clk_en and sr_exit_req to rise together. Grants appear on the second rising edge after sr_ack falls, and sr_exit_req drops on that same edge.
- R8: While running, a change on an enable or mode input reaches the grants on the second rising edge after it (SYNC_STAGES + 1 with the default SYNC_STAGES = 1), and not on the first.
- R9: While rst is 1, and right after it, all grants are 0, mem_clk_en is 1, and both self-refresh requests are 0.
- R10: sr_enter_req and sr_exit_req are never 1 together.
- R11: If an enable returns while self-refresh entry is still awaiting sr_ack, the entry completes: mem_clk_en drops for one cycle and an exit then follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_mode | input | 1 | 0 = normal operation, 1 = halt operation |
| cpu_en | input | 1 | Processor and DMA enable used in normal mode |
| cpu_halt_en | input | 1 | DMA enable used in halt mode |
| disp_en | input | 1 | Display controller enable |
| sr_ack | input | 1 | High while the memory is in self-refresh |
| cpu_grant | output | 1 | Processor may access memory |
| dma_grant | output | 1 | DMA engine may access memory |
| disp_grant | output | 1 | Display controller may access memory |
| mem_clk_en | output | 1 | Enable for the gated memory clock |
| sr_enter_req | output | 1 | Request to enter self-refresh |
| sr_exit_req | output | 1 | Request to leave self-refresh |

## Verification
Two functions can fall in the same cycle. The display enable can return while the self-refresh entry handshake is still waiting for its acknowledge, and the acknowledge then arrives while a requester is already eligible again. The bench provokes this by withholding the acknowledge, raising disp_en during the wait and only then releasing the acknowledge. It judges that no grant leaks out early, that the clock still drops for exactly one cycle, and that an exit request follows before the display grant. A full sweep of the sixteen mode and enable combinations, driven by an acknowledge model that answers every request, checks every grant and the clock enable against the expected table.

// File: rtl/mcg_pkg.sv
package mcg_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ENTER = 2'd1,
    ST_SLEEP = 2'd2,
    ST_EXIT  = 2'd3
  } gate_state_t;

  typedef struct packed {
    logic cpu;
    logic dma;
    logic disp;
  } grant_t;

  localparam int NUM_REQ = $bits(grant_t);

endpackage

// File: rtl/mcg_sync.sv
module mcg_sync #(
  parameter int W      = 5,
  parameter int STAGES = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int LAST = STAGES - 1;

  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '0;
    else     pipe[0] <= d;
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= '0;
        else     pipe[g] <= pipe[g-1];
      end
    end
  endgenerate

  assign q = pipe[LAST];
endmodule

// File: rtl/mcg_access_decode.sv
module mcg_access_decode
  import mcg_pkg::*;
(
  input  logic   halt,
  input  logic   cpu_en,
  input  logic   cpu_halt_en,
  input  logic   disp_en,
  output grant_t want
);
  always_comb begin
    want.cpu  = ~halt & cpu_en;
    want.dma  = halt ? cpu_halt_en : cpu_en;
    want.disp = disp_en;
  end
endmodule

// File: rtl/mcg_sr_sequencer.sv
module mcg_sr_sequencer
  import mcg_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  grant_t want,
  input  logic   ack,
  output grant_t grant,
  output logic   clk_en,
  output logic   enter_req,
  output logic   exit_req
);
  gate_state_t state, state_nx;
  logic        any_want;

  assign any_want = (want != '0);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_RUN:   if (!any_want) state_nx = ST_ENTER;
      ST_ENTER: if (ack)       state_nx = ST_SLEEP;
      ST_SLEEP: if (any_want)  state_nx = ST_EXIT;
      ST_EXIT:  if (!ack)      state_nx = ST_RUN;
      default:                 state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_RUN;
      grant     <= '0;
      clk_en    <= 1'b1;
      enter_req <= 1'b0;
      exit_req  <= 1'b0;
    end else begin
      state     <= state_nx;
      grant     <= (state_nx == ST_RUN) ? want : '0;
      clk_en    <= (state_nx != ST_SLEEP);
      enter_req <= (state_nx == ST_ENTER);
      exit_req  <= (state_nx == ST_EXIT);
    end
  end

  // R6: grants only while the clock runs and no handshake is pending
  p_grant_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (grant != '0) |-> (clk_en && !enter_req && !exit_req));

  // R5: the clock may only fall after self-refresh entry was acknowledged
  p_stop_after_ack_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_en) |-> ($past(ack) && $past(enter_req)));

  // R7: the clock restarts only together with an exit request
  p_wake_via_exit_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_en) |-> exit_req);

  // R10: entry and exit requests are mutually exclusive
  p_req_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({enter_req, exit_req}));
endmodule

// File: rtl/mem_clk_gate.sv
module mem_clk_gate
  import mcg_pkg::*;
#(
  parameter int SYNC_STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic halt_mode,
  input  logic cpu_en,
  input  logic cpu_halt_en,
  input  logic disp_en,
  input  logic sr_ack,
  output logic cpu_grant,
  output logic dma_grant,
  output logic disp_grant,
  output logic mem_clk_en,
  output logic sr_enter_req,
  output logic sr_exit_req
);
  localparam int IN_W = 5;

  logic [IN_W-1:0] raw_in, smp_in;
  logic            s_halt, s_cpu, s_cpuh, s_disp, s_ack;
  grant_t          want, grant;

  assign raw_in = {halt_mode, cpu_en, cpu_halt_en, disp_en, sr_ack};
  assign {s_halt, s_cpu, s_cpuh, s_disp, s_ack} = smp_in;

  mcg_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (smp_in)
  );

  mcg_access_decode u_decode (
    .halt        (s_halt),
    .cpu_en      (s_cpu),
    .cpu_halt_en (s_cpuh),
    .disp_en     (s_disp),
    .want        (want)
  );

  mcg_sr_sequencer u_seq (
    .clk       (clk),
    .rst       (rst),
    .want      (want),
    .ack       (s_ack),
    .grant     (grant),
    .clk_en    (mem_clk_en),
    .enter_req (sr_enter_req),
    .exit_req  (sr_exit_req)
  );

  assign cpu_grant  = grant.cpu;
  assign dma_grant  = grant.dma;
  assign disp_grant = grant.disp;

  // R3: a sampled halt mode never yields a processor grant on the next edge
  p_halt_blocks_cpu_r3: assert property (@(posedge clk) disable iff (rst)
    s_halt |=> !cpu_grant);
endmodule

// File: tb/mem_clk_gate_test.sv
module mem_clk_gate_test;
  localparam time HALF = 5ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic halt_mode = 1'b0, cpu_en = 1'b0, cpu_halt_en = 1'b0, disp_en = 1'b0;
  logic sr_ack = 1'b0;
  logic cpu_grant, dma_grant, disp_grant, mem_clk_en, sr_enter_req, sr_exit_req;

  logic auto_ack = 1'b1;
  logic man_ack  = 1'b0;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #HALF clk = ~clk;

  mem_clk_gate uut (
    .clk(clk), .rst(rst), .halt_mode(halt_mode), .cpu_en(cpu_en),
    .cpu_halt_en(cpu_halt_en), .disp_en(disp_en), .sr_ack(sr_ack),
    .cpu_grant(cpu_grant), .dma_grant(dma_grant), .disp_grant(disp_grant),
    .mem_clk_en(mem_clk_en), .sr_enter_req(sr_enter_req), .sr_exit_req(sr_exit_req)
  );

  // Memory-side model: answers requests, or follows man_ack in manual mode
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (auto_ack) begin
        if (sr_enter_req)     sr_ack = 1'b1;
        else if (sr_exit_req) sr_ack = 1'b0;
      end else begin
        sr_ack = man_ack;
      end
    end
  end

  // {halt, cpu_en, cpu_halt_en, disp_en, exp cpu, exp dma, exp disp, exp clk}
  localparam logic [7:0] VEC [16] = '{
    8'b0_000_0000, 8'b0_001_0011, 8'b0_010_0000, 8'b0_011_0011,
    8'b0_100_1101, 8'b0_101_1111, 8'b0_110_1101, 8'b0_111_1111,
    8'b1_000_0000, 8'b1_001_0011, 8'b1_010_0101, 8'b1_011_0111,
    8'b1_100_0000, 8'b1_101_0011, 8'b1_110_0101, 8'b1_111_0111
  };

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(HALF * 2 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    // R9: reset state
    step(3);
    check("R9", "cpu_grant in reset", cpu_grant, 1'b0);
    check("R9", "dma_grant in reset", dma_grant, 1'b0);
    check("R9", "disp_grant in reset", disp_grant, 1'b0);
    check("R9", "mem_clk_en in reset", mem_clk_en, 1'b1);
    check("R9", "sr_enter_req in reset", sr_enter_req, 1'b0);
    check("R9", "sr_exit_req in reset", sr_exit_req, 1'b0);
    rst = 1'b0;
    check("R9", "mem_clk_en after reset", mem_clk_en, 1'b1);

    // R1/R2/R3/R4: sweep of all mode and enable combinations
    for (int i = 0; i < 16; i++) begin
      {halt_mode, cpu_en, cpu_halt_en, disp_en} = VEC[i][7:4];
      step(12);
      check("R1/R3 sweep", "cpu_grant", cpu_grant, VEC[i][3]);
      check("R1/R3 sweep", "dma_grant", dma_grant, VEC[i][2]);
      check("R2 sweep", "disp_grant", disp_grant, VEC[i][1]);
      check("R4 sweep", "mem_clk_en", mem_clk_en, VEC[i][0]);
      check("R10 sweep", "requests idle", sr_enter_req | sr_exit_req, 1'b0);
    end

    // R8: latency while running
    halt_mode = 1'b0; cpu_en = 1'b1; cpu_halt_en = 1'b0; disp_en = 1'b0;
    step(12);
    disp_en = 1'b1;
    step(1);
    check("R8", "disp_grant after one edge", disp_grant, 1'b0);
    step(1);
    check("R8", "disp_grant after two edges", disp_grant, 1'b1);

    // R3: cpu_en ignored in halt mode
    halt_mode = 1'b1; cpu_halt_en = 1'b0; disp_en = 1'b1;
    step(6);
    for (int k = 0; k < 4; k++) begin
      cpu_en = ~cpu_en;
      step(3);
      check("R3", "cpu_grant with cpu_en toggled", cpu_grant, 1'b0);
      check("R3", "dma_grant with cpu_en toggled", dma_grant, 1'b0);
      check("R3", "disp_grant with cpu_en toggled", disp_grant, 1'b1);
    end

    // R5/R6: entry waits for the acknowledge
    man_ack = 1'b0; auto_ack = 1'b0;
    halt_mode = 1'b0; cpu_en = 1'b0; cpu_halt_en = 1'b0; disp_en = 1'b0;
    step(2);
    check("R5", "sr_enter_req raised", sr_enter_req, 1'b1);
    check("R6", "disp_grant during entry", disp_grant, 1'b0);
    step(10);
    check("R5", "mem_clk_en held without ack", mem_clk_en, 1'b1);
    check("R5", "sr_enter_req held without ack", sr_enter_req, 1'b1);
    man_ack = 1'b1;
    step(1);
    check("R5", "mem_clk_en one edge after ack", mem_clk_en, 1'b1);
    step(1);
    check("R5", "mem_clk_en two edges after ack", mem_clk_en, 1'b0);
    check("R5", "sr_enter_req after stop", sr_enter_req, 1'b0);

    // R7: exit before grants
    disp_en = 1'b1;
    step(2);
    check("R7", "sr_exit_req raised", sr_exit_req, 1'b1);
    check("R7", "mem_clk_en on for exit", mem_clk_en, 1'b1);
    step(5);
    check("R6", "disp_grant while ack still high", disp_grant, 1'b0);
    man_ack = 1'b0;
    step(1);
    check("R7", "disp_grant one edge after ack drop", disp_grant, 1'b0);
    step(1);
    check("R7", "disp_grant two edges after ack drop", disp_grant, 1'b1);
    check("R7", "sr_exit_req cleared", sr_exit_req, 1'b0);

    // R11: enable returns while entry is pending
    disp_en = 1'b0;
    step(3);
    check("R11", "sr_enter_req pending", sr_enter_req, 1'b1);
    disp_en = 1'b1;
    step(4);
    check("R6", "disp_grant while entry pending", disp_grant, 1'b0);
    check("R11", "mem_clk_en still on", mem_clk_en, 1'b1);
    man_ack = 1'b1;
    step(2);
    check("R11", "mem_clk_en dropped after late ack", mem_clk_en, 1'b0);
    step(1);
    check("R11", "exit requested", sr_exit_req, 1'b1);
    check("R11", "mem_clk_en back on", mem_clk_en, 1'b1);
    check("R10", "entry request cleared", sr_enter_req, 1'b0);
    man_ack = 1'b0;
    step(2);
    check("R11", "disp_grant restored", disp_grant, 1'b1);

    done = 1'b1;
    finish_run();
  end
endmodule